// File: doc/BRIEF.md
# GPIO Pin Interrupt Detection Unit

This block watches the eight inputs of a general-purpose input port and turns selected pin activity into one interrupt request for the central interrupt controller. Each pin has its own trigger setup. It can be level-sensitive or edge-sensitive. It can respond to the high level or rising edge, to the low level or falling edge, or, for edge pins, to any change at all. Pin inputs first pass through a two-flop synchronizer. Edges are then found by comparing the synchronized value with its value one cycle earlier.

Trigger events are latched into a raw status vector. A per-pin enable mask then produces a masked status vector, and all masked bits are ORed into the request line. Software reaches the configuration and the status views through a simple single-cycle register port. Status bits are cleared by writing ones to a clear register. The controller, prioritisation, vectoring and alternate pin functions are outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every readable register reads 0x00 and `irq_o` is low.
- R2: Register addresses: 0 = level-select (1 level, 0 edge), 1 = any-edge, 2 = polarity (1 high/rising, 0 low/falling), 3 = enable mask, 4 = raw status (read-only), 5 = masked status (read-only), 6 = clear (write-only, reads 0x00). A written configuration register reads back the written value.
- R3: Pin inputs pass through a two-flop synchronizer. A pin change sampled at clock edge k shows in raw status after edge k+2 and not before.
- R4: On an edge pin with any-edge 0, polarity 1 latches on a rising edge and polarity 0 latches on a falling edge. With any-edge 1, both directions latch whatever the polarity bit holds.
- R5: On a level pin, the raw bit follows the synchronized input: it is 1 while the input is at the active level (high for polarity 1, low for polarity 0). The any-edge bit has no effect on a level pin.
- R6: An edge-latched raw bit stays 1 until a 1 is written to its bit of the clear register. A 0 in the clear data leaves the bit unchanged.
- R7: On a level pin, a clear has no lasting effect while the input stays at the active level.
- R8: If an edge on a pin is detected in the same cycle as a clear of that pin's bit, the raw bit stays 1.
- R9: A masked status bit equals the raw bit AND the enable bit. The enable mask does not change raw status.
- R10: `irq_o` is the OR of all masked status bits.
- R11: A write to address 0, 1 or 2 discards any edge detected in the cycle of that write, so a change of configuration does not latch a spurious edge.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Asynchronous pin inputs |
| reg_wr_i | input | 1 | Register write strobe, taken on the rising clock edge |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the central controller |

## Verification
The bench targets the cycle where an edge and a clear meet on one pin. A design that lets the clear win would lose that interrupt. It also places a configuration write exactly in the cycle where an edge is seen; a design that does not discard that edge would latch a spurious status bit. Level pins are cleared while still active to show that the bit reasserts at once, and any-edge is set on level pins to show it is ignored there. The two-cycle synchronizer latency is sampled on both sides of the expected edge, so a missing or extra flop stage shows up as an early or late status bit.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_LEVEL   = 3'd0,
    REG_ANYEDGE = 3'd1,
    REG_POLHIGH = 3'd2,
    REG_ENABLE  = 3'd3,
    REG_RAW     = 3'd4,
    REG_MASKED  = 3'd5,
    REG_CLEAR   = 3'd6,
    REG_UNUSED  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic level_i,
  input  logic anyedge_i,
  input  logic high_i,
  input  logic clear_i,
  input  logic hist_rst_i,
  output logic prev_o,
  output logic raw_o
);
  logic prev_q, prev_d;
  logic raw_q, raw_d;
  logic rise, fall, hit, active;

  always_comb begin
    rise   = sync_i & ~prev_q;
    fall   = ~sync_i & prev_q;
    if (anyedge_i) begin
      hit = rise | fall;
    end else if (high_i) begin
      hit = rise;
    end else begin
      hit = fall;
    end
    // a configuration write restarts edge history: no edge this cycle
    hit    = hit & ~hist_rst_i;
    active = high_i ? sync_i : ~sync_i;
    prev_d = sync_i;
    if (level_i) begin
      raw_d = active;
    end else begin
      // a new edge wins over a clear in the same cycle
      raw_d = hit | (raw_q & ~clear_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      raw_q  <= raw_d;
    end
  end

  assign prev_o = prev_q;
  assign raw_o  = raw_q;
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0]   raw_i,
  input  logic [NUM_PINS-1:0]   masked_i,
  output logic [NUM_PINS-1:0]   level_o,
  output logic [NUM_PINS-1:0]   anyedge_o,
  output logic [NUM_PINS-1:0]   high_o,
  output logic [NUM_PINS-1:0]   enable_o,
  output logic [NUM_PINS-1:0]   clear_o,
  output logic                  hist_rst_o,
  output logic [NUM_PINS-1:0]   rdata_o
);
  reg_sel_e sel;
  logic wr_level, wr_any, wr_high, wr_en, wr_clr;
  logic [NUM_PINS-1:0] level_q, level_d;
  logic [NUM_PINS-1:0] any_q, any_d;
  logic [NUM_PINS-1:0] high_q, high_d;
  logic [NUM_PINS-1:0] en_q, en_d;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    wr_level = wr_i && (sel == REG_LEVEL);
    wr_any   = wr_i && (sel == REG_ANYEDGE);
    wr_high  = wr_i && (sel == REG_POLHIGH);
    wr_en    = wr_i && (sel == REG_ENABLE);
    wr_clr   = wr_i && (sel == REG_CLEAR);
    level_d  = wr_level ? wdata_i : level_q;
    any_d    = wr_any   ? wdata_i : any_q;
    high_d   = wr_high  ? wdata_i : high_q;
    en_d     = wr_en    ? wdata_i : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      any_q   <= '0;
      high_q  <= '0;
      en_q    <= '0;
    end else begin
      level_q <= level_d;
      any_q   <= any_d;
      high_q  <= high_d;
      en_q    <= en_d;
    end
  end

  always_comb begin
    case (sel)
      REG_LEVEL:   rdata_o = level_q;
      REG_ANYEDGE: rdata_o = any_q;
      REG_POLHIGH: rdata_o = high_q;
      REG_ENABLE:  rdata_o = en_q;
      REG_RAW:     rdata_o = raw_i;
      REG_MASKED:  rdata_o = masked_i;
      default:     rdata_o = '0;
    endcase
  end

  assign level_o    = level_q;
  assign anyedge_o  = any_q;
  assign high_o     = high_q;
  assign enable_o   = en_q;
  assign clear_o    = wr_clr ? wdata_i : '0;
  assign hist_rst_o = wr_level | wr_any | wr_high;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic                  reg_wr_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [NUM_PINS-1:0]   reg_wdata_i,
  output logic [NUM_PINS-1:0]   reg_rdata_o,
  output logic                  irq_o
);
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] pin_prev;
  logic [NUM_PINS-1:0] raw_q;
  logic [NUM_PINS-1:0] masked;
  logic [NUM_PINS-1:0] cfg_level_q, cfg_any_q, cfg_high_q, cfg_en_q;
  logic [NUM_PINS-1:0] clr_bits;
  logic                hist_rst;

  irq_reg_file #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .raw_i      (raw_q),
    .masked_i   (masked),
    .level_o    (cfg_level_q),
    .anyedge_o  (cfg_any_q),
    .high_o     (cfg_high_q),
    .enable_o   (cfg_en_q),
    .clear_o    (clr_bits),
    .hist_rst_o (hist_rst),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_i[g]),
      .q_o    (pin_s[g])
    );

    irq_pin_detect u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sync_i     (pin_s[g]),
      .level_i    (cfg_level_q[g]),
      .anyedge_i  (cfg_any_q[g]),
      .high_i     (cfg_high_q[g]),
      .clear_i    (clr_bits[g]),
      .hist_rst_i (hist_rst),
      .prev_o     (pin_prev[g]),
      .raw_o      (raw_q[g])
    );
  end

  assign masked = raw_q & cfg_en_q;
  assign irq_o  = |masked;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  reg_wr_i,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic [NUM_PINS-1:0]   reg_wdata_i,
  input logic [NUM_PINS-1:0]   reg_rdata_o,
  input logic                  irq_o,
  input logic [NUM_PINS-1:0]   raw_q,
  input logic [NUM_PINS-1:0]   cfg_level_q,
  input logic [NUM_PINS-1:0]   cfg_high_q,
  input logic [NUM_PINS-1:0]   pin_s,
  input logic [NUM_PINS-1:0]   pin_prev
);
  logic [NUM_PINS-1:0] clr_req;
  logic                cfg_wr;

  assign clr_req = (reg_wr_i && reg_addr_i == 3'd6) ? reg_wdata_i : '0;
  assign cfg_wr  = reg_wr_i && (reg_addr_i <= 3'd2);

  assert_irq_needs_raw_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_q != '0));

  assert_clear_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd6) |-> (reg_rdata_o == '0));

  assert_level_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((raw_q ^ ~($past(pin_s) ^ $past(cfg_high_q))) & $past(cfg_level_q)) == '0));

  assert_edge_needs_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_q & ~$past(raw_q) & ~$past(cfg_level_q)
      & ~($past(pin_s) ^ $past(pin_prev))) == '0));

  assert_cfg_write_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_wr) |-> ((raw_q & ~$past(raw_q) & ~$past(cfg_level_q)) == '0));

  assert_clear_takes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_q & $past(clr_req) & ~$past(cfg_level_q)
      & ~($past(pin_s) ^ $past(pin_prev))) == '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .raw_q       (raw_q),
  .cfg_level_q (cfg_level_q),
  .cfg_high_q  (cfg_high_q),
  .pin_s       (pin_s),
  .pin_prev    (pin_prev)
);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {level, anyedge, polarity, enable, pins_before, pins_after, exp_raw, exp_masked}
  localparam logic [63:0] VEC [NVEC] = '{
    64'h00_00_FF_FF_00_0F_0F_0F,
    64'h00_00_00_F0_FF_3C_C3_C0,
    64'h00_FF_00_0F_AA_66_CC_0C,
    64'hFF_00_FF_FF_00_5A_5A_5A,
    64'hFF_FF_00_00_FF_F0_0F_00,
    64'hF0_0C_A5_FF_33_55_06_06,
    64'h00_00_00_FF_00_00_00_00
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = '0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         total = 0;
  int         fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      peek(a[2:0], v);
      check("R1 reset readback", v, 8'h00);
    end
    check("R1 irq after reset", {7'b0, irq}, 8'h00);

    // R2: configuration readback and clear address reads zero
    wreg(3'd0, 8'h81); wreg(3'd1, 8'h42); wreg(3'd2, 8'h24); wreg(3'd3, 8'h18);
    @(negedge clk);
    peek(3'd0, v); check("R2 level readback", v, 8'h81);
    peek(3'd1, v); check("R2 anyedge readback", v, 8'h42);
    peek(3'd2, v); check("R2 polarity readback", v, 8'h24);
    peek(3'd3, v); check("R2 enable readback", v, 8'h18);
    wreg(3'd6, 8'hFF);
    peek(3'd6, v); check("R2 clear reads zero", v, 8'h00);

    // Table walk: R4 edge polarity / any-edge, R5 level, R9 mask, R10 irq
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] t;
      t = VEC[i];
      wreg(3'd0, t[63:56]); wreg(3'd1, t[55:48]);
      wreg(3'd2, t[47:40]); wreg(3'd3, t[39:32]);
      pin = t[31:24];
      settle();
      wreg(3'd6, 8'hFF);
      pin = t[23:16];
      settle();
      peek(3'd4, v); check("R4/R5 table raw", v, t[15:8]);
      peek(3'd5, v); check("R9 table masked", v, t[7:0]);
      check("R10 table irq", {7'b0, irq}, {7'b0, |t[7:0]});
    end

    // R3: synchronizer latency, rising edge on pin 0
    wreg(3'd0, 8'h00); wreg(3'd1, 8'h00); wreg(3'd2, 8'hFF); wreg(3'd3, 8'hFF);
    pin = 8'h00;
    settle();
    wreg(3'd6, 8'hFF);
    pin = 8'h01;              // sampled at the next edge (k)
    @(negedge clk);           // after edge k
    @(negedge clk);           // after edge k+1
    peek(3'd4, v); check("R3 raw not yet at k+1", v, 8'h00);
    @(negedge clk);           // after edge k+2
    peek(3'd4, v); check("R3 raw set after k+2", v, 8'h01);

    // R8: edge on pin 1 coincides with clear of pins 0 and 1
    pin = 8'h03;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 3'd6; wdata = 8'h03;
    @(negedge clk);
    wr = 1'b0;
    peek(3'd4, v); check("R8 edge wins over clear", v, 8'h02);

    // R11: configuration write in the cycle the edge is seen
    wreg(3'd6, 8'hFF);
    pin = 8'h07;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 3'd2; wdata = 8'hFF;
    @(negedge clk);
    wr = 1'b0;
    settle();
    peek(3'd4, v); check("R11 edge discarded on cfg write", v, 8'h00);
    pin = 8'h0F;
    settle();
    peek(3'd4, v); check("R11 later edge still latches", v, 8'h08);

    // R6: sticky status, partial clear, zero write has no effect
    wreg(3'd6, 8'hFF);
    pin = 8'h00;
    settle();
    pin = 8'hFF;
    settle();
    peek(3'd4, v); check("R6 all edges latched", v, 8'hFF);
    settle();
    peek(3'd4, v); check("R6 status sticky", v, 8'hFF);
    wreg(3'd6, 8'h0F);
    peek(3'd4, v); check("R6 partial clear", v, 8'hF0);
    wreg(3'd6, 8'h00);
    peek(3'd4, v); check("R6 zero clear no effect", v, 8'hF0);
    check("R10 irq with pending", {7'b0, irq}, 8'h01);

    // R9: masking leaves raw alone
    wreg(3'd3, 8'h00);
    peek(3'd5, v); check("R9 masked all off", v, 8'h00);
    peek(3'd4, v); check("R9 raw kept under mask", v, 8'hF0);
    check("R10 irq low when masked", {7'b0, irq}, 8'h00);
    wreg(3'd3, 8'h30);
    peek(3'd5, v); check("R9 partial mask", v, 8'h30);
    wreg(3'd3, 8'hFF);
    wreg(3'd6, 8'hF0);
    check("R10 irq low after clear", {7'b0, irq}, 8'h00);

    // R7: level pin clear has no lasting effect
    wreg(3'd0, 8'hFF);
    settle();
    peek(3'd4, v); check("R7 level active", v, 8'hFF);
    wreg(3'd6, 8'hFF);
    peek(3'd4, v); check("R7 clear while active", v, 8'hFF);
    pin = 8'h00;
    settle();
    peek(3'd4, v); check("R5 level released", v, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule